// File: doc/BRIEF.md
# Key-Sequence Guarded Control Register

This block holds a 16-bit control register, split into a low and a high byte, for settings that must not change by accident, such as clock source selection and clock division. It watches a byte-wide write bus that carries at most one access per clock cycle. A plain write to either protected byte has no effect. Software must first write a two-byte key to that byte's own address, one key byte per cycle on back-to-back cycles. The write in the cycle right after the key is accepted. Any later write is ignored again.

Each byte lane has its own key and its own tracker, so unlocking one lane never opens the other. The accepted write either replaces the whole byte or sets or clears one bit of it. The register value is always visible on `reg_q`.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: While `rst_n` is low, `reg_q` equals `RESET_VAL` and both lane trackers are idle. A write in the first cycle after reset is therefore ignored.
- R2: A byte write (`wr_op` = 2'b00) of 0x46 to `LO_ADDR`, followed in the very next cycle by a byte write of 0x57 to `LO_ADDR`, opens the low-byte window for the following cycle.
- R3: A byte write of 0x78 to `HI_ADDR`, followed in the very next cycle by a byte write of 0x9A to `HI_ADDR`, opens the high-byte window for the following cycle.
- R4: Anything other than the second key byte in the cycle after the first key byte aborts the sequence. This includes an idle cycle, a write to any other address, or a non-byte operation.
- R5: The window lasts exactly one cycle. A write two or more cycles after the second key byte is ignored.
- R6: In an open window, `wr_op` 2'b00 replaces the byte with `wr_data`. 2'b01 sets bit `wr_data[2:0]`, 2'b10 clears bit `wr_data[2:0]`, and 2'b11 leaves the byte unchanged. The new value shows on `reg_q` after that clock edge.
- R7: A write of any kind to a protected byte while its window is closed leaves the register unchanged.
- R8: The lanes are independent. A completed low key does not open the high byte, and a completed high key does not open the low byte.
- R9: A wrong byte after the first key byte returns that lane to idle. If the wrong byte is itself the first key byte, the sequence restarts at step one, so 0x46, 0x46, 0x57 still unlocks the low byte.
- R10: Key writes never change the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | A bus write is present this cycle |
| wr_addr | input | ADDR_W | Target address of the write |
| wr_op | input | 2 | Write kind: 00 byte, 01 bit set, 10 bit clear, 11 no effect |
| wr_data | input | 8 | Byte value, or bit index in bits [2:0] |
| reg_q | output | 16 | Protected register, low lane in [7:0] |

## Verification
The bench builds the block with a 3-bit address, low and high bytes at addresses 2 and 5, and a nonzero reset value of 0xA5C3. The narrow address space makes random writes hit the protected bytes and the neighbouring unprotected addresses often. With random data biased toward the four key values, interrupted keys, restarted keys and cross-lane keys occur naturally. The nonzero, mixed-bit reset value lets bit-set and bit-clear results differ from a byte write, and lets a write after reset be seen to have had no effect.

// File: rtl/guarded_ctrl_reg.sv
module guarded_ctrl_reg #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'd1,
  parameter logic [7:0] KEY_LO_A = 8'h46,
  parameter logic [7:0] KEY_LO_B = 8'h57,
  parameter logic [7:0] KEY_HI_A = 8'h78,
  parameter logic [7:0] KEY_HI_B = 8'h9A,
  parameter logic [15:0] RESET_VAL = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_op,
  input  logic [7:0]        wr_data,
  output logic [15:0]       reg_q
);

  localparam logic [1:0] OP_BYTE = 2'b00;
  localparam logic [1:0] OP_SET  = 2'b01;
  localparam logic [1:0] OP_CLR  = 2'b10;

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_ARMED = 2'd1;
  localparam logic [1:0] ST_OPEN  = 2'd2;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = (g == 0) ? LO_ADDR : HI_ADDR;
    localparam logic [7:0] K1 = (g == 0) ? KEY_LO_A : KEY_HI_A;
    localparam logic [7:0] K2 = (g == 0) ? KEY_LO_B : KEY_HI_B;
    localparam logic [7:0] RV = RESET_VAL[8*g +: 8];

    logic [1:0] st, st_nxt;
    logic [7:0] q, q_upd;
    logic hit, k1, k2;

    assign hit = wr_en && (wr_addr == LANE_ADDR);
    assign k1  = hit && (wr_op == OP_BYTE) && (wr_data == K1);
    assign k2  = hit && (wr_op == OP_BYTE) && (wr_data == K2);

    always_comb begin
      case (st)
        ST_IDLE:  st_nxt = k1 ? ST_ARMED : ST_IDLE;
        ST_ARMED: st_nxt = k2 ? ST_OPEN : (k1 ? ST_ARMED : ST_IDLE);
        default:  st_nxt = ST_IDLE;
      endcase
    end

    always_comb begin
      q_upd = q;
      case (wr_op)
        OP_BYTE: q_upd = wr_data;
        OP_SET:  q_upd[wr_data[2:0]] = 1'b1;
        OP_CLR:  q_upd[wr_data[2:0]] = 1'b0;
        default: q_upd = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= ST_IDLE;
        q  <= RV;
      end else begin
        st <= st_nxt;
        if (st == ST_OPEN && hit) q <= q_upd;
      end
    end
  end

  assign reg_q = {g_lane[1].q, g_lane[0].q};

endmodule

module guarded_ctrl_reg_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'd1,
  parameter logic [7:0] KEY_LO_B = 8'h57,
  parameter logic [7:0] KEY_HI_B = 8'h9A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        wr_op,
  input logic [7:0]        wr_data,
  input logic [15:0]       reg_q,
  input logic [1:0]        lo_st,
  input logic [1:0]        hi_st
);

  assert_lo_change_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[7:0] != $past(reg_q[7:0])) |->
      ($past(lo_st) == 2'd2 && $past(wr_en) && $past(wr_addr) == LO_ADDR));

  assert_hi_change_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q[15:8] != $past(reg_q[15:8])) |->
      ($past(hi_st) == 2'd2 && $past(wr_en) && $past(wr_addr) == HI_ADDR));

  assert_lo_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_st == 2'd2) |->
      ($past(wr_en) && $past(wr_addr) == LO_ADDR && $past(wr_op) == 2'b00 &&
       $past(wr_data) == KEY_LO_B && $past(lo_st) == 2'd1));

  assert_hi_open_after_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_st == 2'd2) |->
      ($past(wr_en) && $past(wr_addr) == HI_ADDR && $past(wr_op) == 2'b00 &&
       $past(wr_data) == KEY_HI_B && $past(hi_st) == 2'd1));

  assert_window_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_st == 2'd2 || hi_st == 2'd2) |=> (lo_st != 2'd2 && hi_st != 2'd2));

  assert_idle_cycle_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (lo_st == 2'd0 && hi_st == 2'd0));

endmodule

bind guarded_ctrl_reg guarded_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR),
  .KEY_LO_B(KEY_LO_B), .KEY_HI_B(KEY_HI_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_op(wr_op),
  .wr_data(wr_data), .reg_q(reg_q), .lo_st(g_lane[0].st), .hi_st(g_lane[1].st)
);

// File: tb/guarded_ctrl_reg_bench.sv
`timescale 1ns/1ps
module guarded_ctrl_reg_bench;
  localparam int AW = 3;
  localparam logic [AW-1:0] LO_A = 3'd2;
  localparam logic [AW-1:0] HI_A = 3'd5;
  localparam logic [15:0] RV = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [1:0] wr_op = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic [15:0] reg_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_q;
  int m_st [2];

  always #10 clk = ~clk;

  guarded_ctrl_reg #(.ADDR_W(AW), .LO_ADDR(LO_A), .HI_ADDR(HI_A), .RESET_VAL(RV)) u_guarded_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_op(wr_op),
    .wr_data(wr_data), .reg_q(reg_q)
  );

  function automatic logic [7:0] apply_op(logic [7:0] cur, logic [1:0] op, logic [7:0] d);
    logic [7:0] r = cur;
    if (op == 2'b00) r = d;
    else if (op == 2'b01) r[d[2:0]] = 1'b1;
    else if (op == 2'b10) r[d[2:0]] = 1'b0;
    return r;
  endfunction

  // state: 0 idle, 1 first key seen, 2 window open
  function automatic int next_state(int s, logic hit, logic [1:0] op, logic [7:0] d,
                                    logic [7:0] ka, logic [7:0] kb);
    logic isb = hit && op == 2'b00;
    if (s == 1 && isb && d == kb) return 2;
    if (s != 2 && isb && d == ka) return 1;
    return 0;
  endfunction

  task automatic check(string tag, logic [15:0] exp);
    checks++;
    if (reg_q !== exp) begin
      errors++;
      $display("FAIL %s: reg_q=%h expected %h", tag, reg_q, exp);
    end
  endtask

  task automatic cyc(string tag, logic en, logic [AW-1:0] a, logic [1:0] op, logic [7:0] d);
    logic hl, hh;
    wr_en = en; wr_addr = a; wr_op = op; wr_data = d;
    @(posedge clk);
    hl = en && a == LO_A;
    hh = en && a == HI_A;
    if (m_st[0] == 2 && hl) m_q[7:0] = apply_op(m_q[7:0], op, d);
    if (m_st[1] == 2 && hh) m_q[15:8] = apply_op(m_q[15:8], op, d);
    m_st[0] = next_state(m_st[0], hl, op, d, 8'h46, 8'h57);
    m_st[1] = next_state(m_st[1], hh, op, d, 8'h78, 8'h9A);
    @(negedge clk);
    check(tag, m_q);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    m_q = RV; m_st[0] = 0; m_st[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset value", RV);
    rst_n = 1'b1;
    cyc("R1 write after reset ignored", 1, LO_A, 2'b00, 8'h11);
    check("R1 low byte unchanged", RV);

    cyc("R10 key", 1, LO_A, 0, 8'h46);
    cyc("R10 key", 1, LO_A, 0, 8'h57);
    cyc("R2 low window byte write", 1, LO_A, 0, 8'h3C);
    check("R2 low byte now 3C", {8'hA5, 8'h3C});

    cyc("R10 key", 1, HI_A, 0, 8'h78);
    cyc("R10 key", 1, HI_A, 0, 8'h9A);
    cyc("R6 high clear bit 5", 1, HI_A, 2'b10, 8'h05);
    check("R3 R6 high byte 85", {8'h85, 8'h3C});

    cyc("R4 key", 1, LO_A, 0, 8'h46);
    cyc("R4 idle gap", 0, LO_A, 0, 8'h00);
    cyc("R4 key", 1, LO_A, 0, 8'h57);
    cyc("R4 write ignored", 1, LO_A, 0, 8'hFF);
    cyc("R4 key", 1, LO_A, 0, 8'h46);
    cyc("R4 other addr", 1, 3'd0, 0, 8'h46);
    cyc("R4 key", 1, LO_A, 0, 8'h57);
    cyc("R4 write ignored", 1, LO_A, 0, 8'hFF);
    cyc("R4 key", 1, LO_A, 0, 8'h46);
    cyc("R4 set op breaks key", 1, LO_A, 2'b01, 8'h57);
    cyc("R4 write ignored", 1, LO_A, 0, 8'hFF);
    check("R4 low byte kept 3C", {8'h85, 8'h3C});

    cyc("R5 key", 1, LO_A, 0, 8'h46);
    cyc("R5 key", 1, LO_A, 0, 8'h57);
    cyc("R5 idle in window", 0, LO_A, 0, 8'h00);
    cyc("R5 late write ignored", 1, LO_A, 0, 8'h00);
    check("R5 low byte kept 3C", {8'h85, 8'h3C});

    cyc("R8 key", 1, LO_A, 0, 8'h46);
    cyc("R8 key", 1, LO_A, 0, 8'h57);
    cyc("R8 high write ignored", 1, HI_A, 0, 8'h00);
    cyc("R8 high key at low addr", 1, LO_A, 0, 8'h78);
    cyc("R8 high key at low addr", 1, LO_A, 0, 8'h9A);
    cyc("R8 low write ignored", 1, LO_A, 0, 8'h00);
    check("R8 both bytes kept", {8'h85, 8'h3C});

    cyc("R9 key", 1, LO_A, 0, 8'h46);
    cyc("R9 repeat first key", 1, LO_A, 0, 8'h46);
    cyc("R9 key", 1, LO_A, 0, 8'h57);
    cyc("R9 R6 set bit 7", 1, LO_A, 2'b01, 8'h07);
    check("R9 restart opens low", {8'h85, 8'hBC});
    cyc("R9 key", 1, LO_A, 0, 8'h46);
    cyc("R9 wrong byte", 1, LO_A, 0, 8'h11);
    cyc("R9 key", 1, LO_A, 0, 8'h57);
    cyc("R9 write ignored", 1, LO_A, 0, 8'h00);
    check("R9 wrong byte aborts", {8'h85, 8'hBC});

    cyc("R6 key", 1, HI_A, 0, 8'h78);
    cyc("R6 key", 1, HI_A, 0, 8'h9A);
    cyc("R6 op 11 no effect", 1, HI_A, 2'b11, 8'h00);
    check("R6 reserved op", {8'h85, 8'hBC});
    cyc("R7 closed write ignored", 1, HI_A, 2'b01, 8'h01);
    check("R7 high kept", {8'h85, 8'hBC});

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic [AW-1:0] a;
      int pick = int'($urandom_range(0, 5));
      case (pick)
        0: d = 8'h46; 1: d = 8'h57; 2: d = 8'h78; 3: d = 8'h9A;
        default: d = 8'($urandom);
      endcase
      a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : (($urandom_range(0, 1) == 0) ? LO_A : HI_A);
      cyc("R7 random", ($urandom_range(0, 9) != 0), a,
          ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00, d);
    end
    finish_run();
  end

  initial void'($urandom(32'd1234));
endmodule